// File: doc/BRIEF.md
# Checked Store Buffer for Redundant Execution

This block sits between a leading core and memory in a pair of cores that run the same program twice for fault detection. Every store the leading core commits goes into the buffer instead of to memory. The trailing core later presents its own copy of each store, in program order. The buffer compares that copy with the oldest store that has not yet been checked. Only stores whose address and data both agree are written to memory. A store that disagrees raises a sticky error flag and is discarded.

While stores wait in the buffer, the leading core's loads search every occupied slot in the same cycle as the cache access. When one or more slots hold the load address, the data from the most recently enqueued of them is forwarded.

Three streams use valid/ready handshakes. On the store-enqueue stream, ready drops while every slot is occupied, so the leading core holds its store. On the verify stream, ready drops while no unchecked store is held, so the trailing core waits. On the memory-write stream, the buffer holds valid, address and data steady until memory accepts them. The lookup port and the error flag are plain signals.

Top module: `checked_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `lead_ready` is 1, `trail_ready` is 0, `mem_valid` is 0, `mismatch` is 0 and `lk_hit` is 0.
- R2: A store is accepted on a cycle with `lead_valid` and `lead_ready` both high. `lead_ready` is 0 exactly while all DEPTH slots are occupied, and a store offered then is not taken.
- R3: `mem_valid` is raised only for a store whose check passed. Stores reach memory in the order they were enqueued, carrying the address and data given at enqueue.
- R4: A verify handshake always compares against the oldest unchecked store, in enqueue order. `trail_ready` is 0 exactly while no unchecked store is held.
- R5: A verify whose address or data differs from the oldest unchecked store sets `mismatch` from the next cycle until reset. The failing store is removed without ever raising `mem_valid`.
- R6: Once `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` stay unchanged on the next cycle. A slot is freed by the cycle with `mem_valid` and `mem_ready` both high.
- R7: `lk_hit` is 1 when any occupied slot, checked or not, holds an address equal to `lk_addr` over all AW bits. `lk_data` is then the data of the most recently enqueued such slot.
- R8: When no occupied slot matches, `lk_hit` is 0 and `lk_data` is 0.
- R9: Lookup is combinational on registered state. A store can be found from the cycle after its enqueue handshake until the cycle of its memory handshake (or its removal after a failed check), and not after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading-core store offered |
| lead_ready | output | 1 | Buffer has a free slot |
| lead_addr | input | AW | Leading-core store address |
| lead_data | input | DW | Leading-core store data |
| trail_valid | input | 1 | Trailing-core store copy offered |
| trail_ready | output | 1 | An unchecked store is waiting |
| trail_addr | input | AW | Trailing-core store address |
| trail_data | input | DW | Trailing-core store data |
| lk_addr | input | AW | Load lookup address |
| lk_hit | output | 1 | Some occupied slot matches lk_addr |
| lk_data | output | DW | Forwarded data from youngest match, else 0 |
| mem_valid | output | 1 | Checked store presented to memory |
| mem_ready | input | 1 | Memory accepts the store |
| mem_addr | output | AW | Store address to memory |
| mem_data | output | DW | Store data to memory |
| mismatch | output | 1 | Sticky flag: a check failed |

## Verification
A slip in the verify pointer shows on the very next verify handshake: a correct trailing copy is judged against the wrong slot, and `mismatch` rises one cycle later even though no fault was injected. A bad occupancy count shows as `lead_ready` or `trail_ready` being wrong in the same cycle the count crosses a boundary. A stale or wrongly cleared slot state shows at once on the lookup port, as a hit on a freed slot or the wrong youngest match. A broken drain shows as a write to memory out of order or from an unchecked slot, on the first handshake after the fault.

// File: rtl/csb_pkg.sv
package csb_pkg;
  // Life cycle of one buffer slot.
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,  // empty
    SLOT_PEND = 2'd1,  // written by leading core, not yet checked
    SLOT_PASS = 2'd2,  // checked, matches, waiting for memory
    SLOT_FAIL = 2'd3   // checked, differs, to be dropped
  } slot_state_e;
endpackage

// File: rtl/csb_store.sv
module csb_store
  import csb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [PW-1:0]                wr_idx,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic                         chk_en,
  input  logic [PW-1:0]                chk_idx,
  input  logic                         chk_pass,
  input  logic                         free_en,
  input  logic [PW-1:0]                free_idx,
  output logic [DEPTH-1:0][AW-1:0]     addr_q,
  output logic [DEPTH-1:0][DW-1:0]     data_q,
  output slot_state_e [DEPTH-1:0]      state_q
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        state_q[s] <= SLOT_FREE;
      end else if (wr_en && wr_idx == PW'(s)) begin
        state_q[s] <= SLOT_PEND;
      end else if (chk_en && chk_idx == PW'(s)) begin
        state_q[s] <= chk_pass ? SLOT_PASS : SLOT_FAIL;
      end else if (free_en && free_idx == PW'(s)) begin
        state_q[s] <= SLOT_FREE;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[s] <= '0;
        data_q[s] <= '0;
      end else if (wr_en && wr_idx == PW'(s)) begin
        addr_q[s] <= wr_addr;
        data_q[s] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/csb_fwd.sv
module csb_fwd
  import csb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 4
) (
  input  logic [DEPTH-1:0][AW-1:0] addr_q,
  input  logic [DEPTH-1:0][DW-1:0] data_q,
  input  slot_state_e [DEPTH-1:0]  state_q,
  input  logic [PW-1:0]            head,
  input  logic [AW-1:0]            lk_addr,
  output logic                     lk_hit,
  output logic [DW-1:0]            lk_data
);
  localparam int GW = PW + 1;

  logic [DEPTH-1:0]         hit;
  logic [DEPTH-1:0][GW-1:0] age;

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign hit[s] = (state_q[s] != SLOT_FREE) && (addr_q[s] == lk_addr);
    assign age[s] = (PW'(s) >= head) ? GW'(PW'(s) - head)
                                     : GW'(s) + GW'(DEPTH) - GW'(head);
  end

  always_comb begin
    logic [GW-1:0] best;
    lk_hit  = 1'b0;
    lk_data = '0;
    best    = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (hit[s] && (!lk_hit || age[s] > best)) begin
        lk_hit  = 1'b1;
        lk_data = data_q[s];
        best    = age[s];
      end
    end
  end
endmodule

// File: rtl/csb_ctrl.sv
module csb_ctrl
  import csb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lead_valid,
  input  logic          trail_valid,
  input  logic [AW-1:0] trail_addr,
  input  logic [DW-1:0] trail_data,
  input  logic          mem_ready,
  input  logic [AW-1:0] chk_addr,
  input  logic [DW-1:0] chk_data,
  input  slot_state_e   head_state,
  output logic          lead_ready,
  output logic          trail_ready,
  output logic          mem_valid,
  output logic          enq,
  output logic          ver,
  output logic          ver_pass,
  output logic          drain,
  output logic [PW-1:0] head,
  output logic [PW-1:0] vptr,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] nver,
  output logic          mismatch
);
  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic have_ver;

  assign have_ver    = (nver != '0);
  assign lead_ready  = (occ != CW'(DEPTH));
  assign trail_ready = (occ != nver);
  assign mem_valid   = have_ver && (head_state == SLOT_PASS);
  assign enq         = lead_valid && lead_ready;
  assign ver         = trail_valid && trail_ready;
  assign ver_pass    = (trail_addr == chk_addr) && (trail_data == chk_data);
  assign drain       = have_ver && ((head_state == SLOT_FAIL) || mem_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      vptr     <= '0;
      tail     <= '0;
      occ      <= '0;
      nver     <= '0;
      mismatch <= 1'b0;
    end else begin
      if (enq)   tail <= step_ptr(tail);
      if (ver)   vptr <= step_ptr(vptr);
      if (drain) head <= step_ptr(head);
      occ      <= occ + CW'(enq) - CW'(drain);
      nver     <= nver + CW'(ver) - CW'(drain);
      mismatch <= mismatch | (ver && !ver_pass);
    end
  end
endmodule

// File: rtl/checked_store_buffer.sv
module checked_store_buffer
  import csb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lead_valid,
  output logic          lead_ready,
  input  logic [AW-1:0] lead_addr,
  input  logic [DW-1:0] lead_data,
  input  logic          trail_valid,
  output logic          trail_ready,
  input  logic [AW-1:0] trail_addr,
  input  logic [DW-1:0] trail_data,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          mismatch
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  slot_state_e [DEPTH-1:0]  state_q;
  logic                     enq, ver, ver_pass, drain;
  logic [PW-1:0]            head, vptr, tail;
  logic [CW-1:0]            occ, nver;

  csb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (enq),
    .wr_idx   (tail),
    .wr_addr  (lead_addr),
    .wr_data  (lead_data),
    .chk_en   (ver),
    .chk_idx  (vptr),
    .chk_pass (ver_pass),
    .free_en  (drain),
    .free_idx (head),
    .addr_q   (addr_q),
    .data_q   (data_q),
    .state_q  (state_q)
  );

  csb_ctrl #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .lead_valid  (lead_valid),
    .trail_valid (trail_valid),
    .trail_addr  (trail_addr),
    .trail_data  (trail_data),
    .mem_ready   (mem_ready),
    .chk_addr    (addr_q[vptr]),
    .chk_data    (data_q[vptr]),
    .head_state  (state_q[head]),
    .lead_ready  (lead_ready),
    .trail_ready (trail_ready),
    .mem_valid   (mem_valid),
    .enq         (enq),
    .ver         (ver),
    .ver_pass    (ver_pass),
    .drain       (drain),
    .head        (head),
    .vptr        (vptr),
    .tail        (tail),
    .occ         (occ),
    .nver        (nver),
    .mismatch    (mismatch)
  );

  csb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) u_fwd (
    .addr_q  (addr_q),
    .data_q  (data_q),
    .state_q (state_q),
    .head    (head),
    .lk_addr (lk_addr),
    .lk_hit  (lk_hit),
    .lk_data (lk_data)
  );

  assign mem_addr = addr_q[head];
  assign mem_data = data_q[head];
endmodule

// File: rtl/csb_chk.sv
module csb_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lead_ready,
  input logic          trail_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          mismatch,
  input logic          lk_hit,
  input logic [DW-1:0] lk_data,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] nver
);
  // R2: occupancy never exceeds the slot count
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R4: checked-but-undrained stores never outnumber held stores
  p_ver_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nver <= occ);

  // R3: an empty buffer offers nothing to memory or to the trailing core
  p_empty_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (!mem_valid && !trail_ready && lead_ready));

  // R5: error flag is sticky
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> mismatch);

  // R6: stalled memory write holds steady
  p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R8: a miss forwards zero
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_data == '0));
endmodule

bind checked_store_buffer csb_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lead_ready  (lead_ready),
  .trail_ready (trail_ready),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_data    (mem_data),
  .mismatch    (mismatch),
  .lk_hit      (lk_hit),
  .lk_data     (lk_data),
  .occ         (occ),
  .nver        (nver)
);

// File: tb/checked_store_buffer_tb.sv
module checked_store_buffer_tb;
  localparam int DEPTH = 8;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int MQ    = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lead_valid = 1'b0, trail_valid = 1'b0, mem_ready = 1'b0;
  logic [AW-1:0] lead_addr = '0, trail_addr = '0, lk_addr = '0;
  logic [DW-1:0] lead_data = '0, trail_data = '0;
  logic          lead_ready, trail_ready, lk_hit, mem_valid, mismatch;
  logic [DW-1:0] lk_data, mem_data;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;  // 50 MHz

  checked_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lead_valid(lead_valid), .lead_ready(lead_ready),
    .lead_addr(lead_addr), .lead_data(lead_data),
    .trail_valid(trail_valid), .trail_ready(trail_ready),
    .trail_addr(trail_addr), .trail_data(trail_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mismatch(mismatch)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model: ring of stores with absolute indices.
  logic [AW-1:0] m_addr [MQ];
  logic [DW-1:0] m_data [MQ];
  int            m_st   [MQ];  // 0 unchecked, 1 passed, 2 failed
  int            mh = 0, mv = 0, mt = 0;
  bit            m_mm = 1'b0;
  bit            e_ldr, e_trr, e_mv, e_hit;
  logic [DW-1:0] e_lkd;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit lk_model_hit(input logic [AW-1:0] a);
    for (int k = mh; k < mt; k++) if (m_addr[k % MQ] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [DW-1:0] lk_model_data(input logic [AW-1:0] a);
    logic [DW-1:0] d = '0;
    for (int k = mh; k < mt; k++) if (m_addr[k % MQ] == a) d = m_data[k % MQ];
    return d;
  endfunction

  task automatic compare_all();
    e_ldr = (mt - mh) < DEPTH;
    e_trr = mv < mt;
    e_mv  = (mv > mh) && (m_st[mh % MQ] == 1);
    e_hit = lk_model_hit(lk_addr);
    e_lkd = lk_model_data(lk_addr);
    check("R2", "lead_ready", 32'(lead_ready), 32'(e_ldr));
    check("R4", "trail_ready", 32'(trail_ready), 32'(e_trr));
    check("R3", "mem_valid", 32'(mem_valid), 32'(e_mv));
    if (e_mv) begin
      check("R3", "mem_addr", 32'(mem_addr), 32'(m_addr[mh % MQ]));
      check("R6", "mem_data", 32'(mem_data), 32'(m_data[mh % MQ]));
    end
    check("R5", "mismatch", 32'(mismatch), 32'(m_mm));
    check("R7", "lk_hit", 32'(lk_hit), 32'(e_hit));   // R9 visibility window via model
    check(e_hit ? "R7" : "R8", "lk_data", 32'(lk_data), 32'(e_lkd));
  endtask

  // bad: 0 faithful copy, 1 corrupt data, 2 corrupt address
  task automatic step(input bit lv, input bit tv, input bit mr, input int bad);
    bit do_enq, do_ver, do_drain, pass;
    @(negedge clk);
    lead_valid = lv;
    lead_addr  = AW'($urandom % 8);
    lead_data  = DW'($urandom);
    if (mv < mt) begin
      trail_addr = m_addr[mv % MQ];
      trail_data = m_data[mv % MQ];
    end else begin
      trail_addr = AW'($urandom % 8);
      trail_data = DW'($urandom);
    end
    if (bad == 1) trail_data = trail_data ^ DW'(1);
    if (bad == 2) trail_addr = trail_addr ^ AW'(1);
    trail_valid = tv;
    mem_ready   = mr;
    lk_addr     = AW'($urandom % 8);
    #1;
    compare_all();
    do_enq   = lv && e_ldr;
    do_ver   = tv && e_trr;
    do_drain = (mv > mh) && ((m_st[mh % MQ] == 2) || mr);
    pass     = do_ver && (trail_addr == m_addr[mv % MQ]) && (trail_data == m_data[mv % MQ]);
    @(posedge clk);
    if (do_drain) mh++;
    if (do_ver) begin
      m_st[mv % MQ] = pass ? 1 : 2;
      if (!pass) m_mm = 1'b1;
      mv++;
    end
    if (do_enq) begin
      m_addr[mt % MQ] = lead_addr;
      m_data[mt % MQ] = lead_data;
      m_st[mt % MQ]   = 0;
      mt++;
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: empty after reset
    check("R1", "lead_ready", 32'(lead_ready), 32'd1);
    check("R1", "trail_ready", 32'(trail_ready), 32'd0);
    check("R1", "mem_valid", 32'(mem_valid), 32'd0);
    check("R1", "mismatch", 32'(mismatch), 32'd0);
    check("R1", "lk_hit", 32'(lk_hit), 32'd0);

    // R2: fill past capacity with no checking, stores beyond DEPTH refused
    for (int i = 0; i < DEPTH + 3; i++) step(1'b1, 1'b0, 1'b0, 0);
    // R4, R6: check all while memory stalls, then release
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1, 1'b0, 0);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b0, 1'b1, 0);
    // Random traffic, faithful copies
    for (int i = 0; i < 4000; i++)
      step(($urandom % 2) == 0, ($urandom % 5) < 2, ($urandom % 5) < 3, 0);
    // R5: data difference, then address difference
    step(1'b1, 1'b0, 1'b0, 0);
    step(1'b0, 1'b1, 1'b0, 1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, 0);
    step(1'b1, 1'b0, 1'b0, 0);
    step(1'b0, 1'b1, 1'b0, 2);
    for (int i = 0; i < 1500; i++)
      step(($urandom % 2) == 0, ($urandom % 5) < 2, ($urandom % 4) != 0,
           (($urandom % 50) == 0) ? 1 : 0);
    for (int i = 0; i < 3 * DEPTH; i++) step(1'b0, 1'b1, 1'b1, 0);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule